// File: doc/BRIEF.md
# Page Buffer Burst Read Packer

This block answers read requests aimed at a 16-byte page buffer. With burst mode off, a read returns one buffer byte, zero-extended onto the output word. With burst mode on, one read request produces a short run of one to three output words. Each word packs 1, 2 or 4 consecutive buffer bytes, in the byte order chosen at run time. The words leave on a valid/ready stream.

A write-only configuration register holds the packing width, the byte order and the word count. The bus writes it at address 0x5D. The block reads the buffer through a byte port with combinational read data, one byte per cycle. The buffer pointer wraps from byte 15 to byte 0. A new request is held off until the consumer has taken the last word of the current burst.

Top module: `pgbuf_burst_packer`

## Requirements
- R1: After a synchronous active-low reset, rd_ready is 1 and out_valid is 0. The configuration is all-zero, so burst mode is off.
- R2: The configuration is written only when cfg_wr is high and cfg_addr equals 0x5D. A write to any other address leaves the configuration unchanged.
- R3: The configuration fields are: word count in bits 11:8, byte order in bit 4, width code in bits 1:0. A word count of 0 turns burst mode off. A request then yields exactly one word, whose bits 7:0 hold the byte at rd_offset and whose upper bits are zero, whatever the width code and byte order.
- R4: Width code 00 packs 1 byte, 01 packs 2 bytes, 10 packs 4 bytes, and 11 packs 1 byte.
- R5: With bit 4 = 0 (little-endian), the byte at the lowest buffer index of a word sits in bits 7:0, and each following byte sits 8 bits higher.
- R6: With bit 4 = 1 (big-endian), the byte at the lowest buffer index sits in the most significant byte of the selected width. Bits above that width are zero.
- R7: A word count of 1 to 3 yields that many words, and any count above 3 yields 3. Each word takes the bytes that follow the previous word. out_last is 1 on the final word only.
- R8: The buffer index wraps modulo 16, so byte 15 is followed by byte 0.
- R9: rd_ready goes low from the cycle after a request is accepted until the final word has been transferred. A request presented while rd_ready is low is ignored.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R11: The configuration is captured when a request is accepted. A configuration write during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Bus write strobe |
| cfg_addr | input | 8 | Bus write address |
| cfg_wdata | input | 16 | Bus write data |
| rd_req | input | 1 | Read request |
| rd_offset | input | 4 | Starting buffer byte index of the request |
| rd_ready | output | 1 | Block can accept a request |
| pbuf_addr | output | 4 | Byte index into the page buffer |
| pbuf_data | input | 8 | Byte read from the page buffer (combinational) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | BUS_W | Packed output word |
| out_last | output | 1 | Final word of the burst |

## Verification
The hardest case to reach from the ports is a change made while a burst is still running. This covers a second request, and a configuration rewrite, arriving while words are still pending. The bench fires both in the first cycle after acceptance. It then checks that the burst finishes with its captured settings and its original offset. Throttling out_ready in a fixed pattern creates stalls in the middle of a word sequence. The bench uses these stalls to confirm that values hold during backpressure, and it uses offsets near 15 to push multi-word bursts across the wrap point.

// File: rtl/pgb_pkg.sv
// Package: shared types and decode helpers for the page buffer burst packer.
// Assumes a bus data width of 16 or 32 bits.
package pgb_pkg;

    localparam logic [7:0] BURST_CFG_ADDR = 8'h5D;

    typedef enum logic [1:0] {
        PK_W8  = 2'b00,
        PK_W16 = 2'b01,
        PK_W32 = 2'b10,
        PK_WX  = 2'b11
    } pack_width_e;

    typedef struct packed {
        logic [3:0]  nwords;
        logic        big_end;
        pack_width_e width;
    } burst_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GATHER  = 2'd1,
        ST_PRESENT = 2'd2
    } burst_state_e;

    // Bytes per word. Burst off forces one byte. A width the bus cannot carry is narrowed.
    function automatic logic [2:0] word_bytes(burst_cfg_t c, int unsigned bus_bytes);
        logic [2:0] b;
        if (c.nwords == 4'd0) b = 3'd1;
        else begin
            case (c.width)
                PK_W16:  b = 3'd2;
                PK_W32:  b = 3'd4;
                default: b = 3'd1;
            endcase
        end
        if (32'(b) > bus_bytes) b = (bus_bytes >= 2) ? 3'd2 : 3'd1;
        return b;
    endfunction

    // Words per request: 0 means a single word, and counts above 3 become 3.
    function automatic logic [1:0] word_count(burst_cfg_t c);
        if (c.nwords == 4'd0) return 2'd1;
        if (c.nwords > 4'd3)  return 2'd3;
        return c.nwords[1:0];
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
// Module: write-only burst configuration register.
// Loads the width, order and count fields when the bus writes the
// configuration address. Writes to other addresses are ignored.
module burst_cfg_reg
    import pgb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [3:0] wr_count,
    input  logic       wr_big,
    input  logic [1:0] wr_width,
    output burst_cfg_t cfg
);

    // Capture the fields on a write that decodes to this register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && wr_addr == BURST_CFG_ADDR) begin
            cfg.nwords  <= wr_count;
            cfg.big_end <= wr_big;
            cfg.width   <= pack_width_e'(wr_width);
        end
    end

    assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != BURST_CFG_ADDR) |=> $stable(cfg));

endmodule

// File: rtl/pack_accum.sv
// Module: byte accumulator that builds one packed word.
// On the first byte of a word (idx 0) it starts from zero.
// In big-endian mode it shifts the word left and puts the new byte low.
// In little-endian mode it places byte idx at bit 8*idx.
module pack_accum #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       idx,
    input  logic             big,
    input  logic [7:0]       byte_in,
    output logic [BUS_W-1:0] word
);

    logic [BUS_W-1:0] base;
    logic [BUS_W-1:0] next;

    // Choose the starting value and merge the incoming byte.
    always_comb begin
        base = (idx == 2'd0) ? '0 : word;
        next = base;
        if (big) next = {base[BUS_W-9:0], byte_in};
        else     next[8*int'(idx) +: 8] = byte_in;
    end

    // Hold the word between loads.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= '0;
        else if (load) word <= next;
    end

    assert_big_low_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && big) |=> word[7:0] == $past(byte_in));
    assert_little_first_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !big && idx == 2'd0) |=> word == BUS_W'($past(byte_in)));

endmodule

// File: rtl/burst_ctrl.sv
// Module: burst sequencer.
// On an accepted request it captures the configuration and steps the
// buffer pointer one byte per cycle (wrapping at 16). After each word's
// bytes it presents the word and waits for the consumer. rd_ready is
// high only in the idle state.
module burst_ctrl
    import pgb_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  burst_cfg_t cfg,
    input  logic       rd_req,
    input  logic [3:0] rd_offset,
    output logic       rd_ready,
    output logic [3:0] buf_addr,
    output logic       acc_load,
    output logic [1:0] acc_idx,
    output logic       acc_big,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last
);

    localparam int unsigned BUS_BYTES = BUS_W / 8;

    burst_state_e state;
    logic [3:0]   ptr;
    logic [1:0]   bidx;
    logic [2:0]   nb;
    logic [1:0]   nw;
    logic [1:0]   wcnt;
    logic         big;
    logic         word_done;

    // Decode the outputs and the end of a word from the state.
    always_comb begin
        rd_ready  = (state == ST_IDLE);
        out_valid = (state == ST_PRESENT);
        out_last  = out_valid && (wcnt == nw);
        acc_load  = (state == ST_GATHER);
        word_done = ({1'b0, bidx} == nb - 3'd1);
    end

    assign buf_addr = ptr;
    assign acc_idx  = bidx;
    assign acc_big  = big;

    // Sequence the burst: capture on accept, gather bytes, present words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            bidx  <= '0;
            nb    <= 3'd1;
            nw    <= 2'd1;
            wcnt  <= 2'd1;
            big   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (rd_req) begin
                    ptr   <= rd_offset;
                    bidx  <= '0;
                    nb    <= word_bytes(cfg, BUS_BYTES);
                    nw    <= word_count(cfg);
                    big   <= cfg.big_end && (cfg.nwords != 4'd0);
                    wcnt  <= 2'd1;
                    state <= ST_GATHER;
                end
                ST_GATHER: begin
                    ptr <= ptr + 4'd1;
                    if (word_done) begin
                        bidx  <= '0;
                        state <= ST_PRESENT;
                    end else begin
                        bidx <= bidx + 2'd1;
                    end
                end
                ST_PRESENT: if (out_ready) begin
                    if (wcnt == nw) state <= ST_IDLE;
                    else begin
                        wcnt  <= wcnt + 2'd1;
                        state <= ST_GATHER;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> !rd_ready);
    assert_free_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> rd_ready);
    assert_pointer_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_load && $past(acc_load)) |-> buf_addr == $past(buf_addr) + 4'd1);
    assert_word_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wcnt <= nw));

endmodule

// File: rtl/pgbuf_burst_packer.sv
// Module: top of the page buffer burst read packer.
// Connects the configuration register, the sequencer and the accumulator.
// Assumes pbuf_data is valid in the same cycle pbuf_addr is driven.
module pgbuf_burst_packer #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [15:0]      cfg_wdata,
    input  logic             rd_req,
    input  logic [3:0]       rd_offset,
    output logic             rd_ready,
    output logic [3:0]       pbuf_addr,
    input  logic [7:0]       pbuf_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BUS_W-1:0] out_data,
    output logic             out_last
);

    pgb_pkg::burst_cfg_t cfg;
    logic                acc_load;
    logic [1:0]          acc_idx;
    logic                acc_big;
    logic                unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[15:12], cfg_wdata[7:5], cfg_wdata[3:2]};

    burst_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_addr  (cfg_addr),
        .wr_count (cfg_wdata[11:8]),
        .wr_big   (cfg_wdata[4]),
        .wr_width (cfg_wdata[1:0]),
        .cfg      (cfg)
    );

    burst_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .rd_req    (rd_req),
        .rd_offset (rd_offset),
        .rd_ready  (rd_ready),
        .buf_addr  (pbuf_addr),
        .acc_load  (acc_load),
        .acc_idx   (acc_idx),
        .acc_big   (acc_big),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last)
    );

    pack_accum #(.BUS_W(BUS_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (acc_load),
        .idx     (acc_idx),
        .big     (acc_big),
        .byte_in (pbuf_data),
        .word    (out_data)
    );

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_ready && !out_valid));

endmodule

// File: tb/tb_pgbuf_burst_packer.sv
`timescale 1ns/1ps
module tb_pgbuf_burst_packer;

    localparam int BUS_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_addr = '0;
    logic [15:0]      cfg_wdata = '0;
    logic             rd_req = 1'b0;
    logic [3:0]       rd_offset = '0;
    logic             rd_ready;
    logic [3:0]       pbuf_addr;
    logic [7:0]       pbuf_data;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [BUS_W-1:0] out_data;
    logic             out_last;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pgbuf_burst_packer #(.BUS_W(BUS_W)) dut (.*);

    function automatic logic [7:0] pb(input int i);
        return 8'(8'h3C + (i % 16) * 8'h17);
    endfunction
    assign pbuf_data = pb(int'(pbuf_addr));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected values from the requirements.
    function automatic int exp_bytes(input logic [15:0] c);
        if (c[11:8] == 4'd0) return 1;
        case (c[1:0]) 2'b01: return 2; 2'b10: return 4; default: return 1; endcase
    endfunction
    function automatic int exp_words(input logic [15:0] c);
        if (c[11:8] == 4'd0) return 1;
        return (c[11:8] > 4'd3) ? 3 : int'(c[11:8]);
    endfunction
    function automatic logic [31:0] exp_word(input logic [15:0] c, input int off, input int k);
        logic [31:0] w = '0;
        int nb = exp_bytes(c);
        bit be = c[4] && (c[11:8] != 4'd0);
        for (int j = 0; j < nb; j++) begin
            if (be) w = (w << 8) | 32'(pb(off + k * nb + j));
            else    w = w | (32'(pb(off + k * nb + j)) << (8 * j));
        end
        return w;
    endfunction

    // Vector table: {config word, offset}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {16'h0000, 4'd5},   // R3 burst off
        {16'h0113, 4'd2},   // R4 code 11 -> 8 bit
        {16'h0301, 4'd14},  // R5 R8 16-bit LE wrap
        {16'h0211, 4'd7},   // R6 16-bit BE
        {16'h0302, 4'd12},  // R5 R8 32-bit LE wrap
        {16'h0212, 4'd3},   // R6 32-bit BE
        {16'h0F12, 4'd0},   // R7 count clamps to 3
        {16'h0012, 4'd9}    // R3 width/order ignored when off
    };

    logic [31:0] got [4];
    logic        gl  [4];
    int          ngot;

    task automatic write_cfg(input logic [7:0] a, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue a request and collect words; optional stalls and a mid-burst poke.
    task automatic run_read(input logic [3:0] off, input bit stall, input bit poke);
        bit done = 0;
        bit held = 0;
        logic [31:0] held_val = '0;
        ngot = 0;
        rd_req = 1'b1; rd_offset = off;
        @(posedge clk); @(negedge clk);
        rd_req = 1'b0;
        for (int t = 0; t < 100 && !done; t++) begin
            if (poke && t == 0) begin
                chk(rd_ready == 1'b0, "R9 busy after accept", 32'(rd_ready), 32'd0);
                rd_req = 1'b1; rd_offset = off + 4'd5;
                cfg_wr = 1'b1; cfg_addr = 8'h5D; cfg_wdata = 16'h0000;
            end else begin
                rd_req = 1'b0; cfg_wr = 1'b0;
            end
            out_ready = stall ? (t % 3 == 2) : 1'b1;
            if (held && out_valid)
                chk(out_data == held_val, "R10 data held under stall", out_data, held_val);
            held = out_valid && !out_ready;
            held_val = out_data;
            if (out_valid && out_ready && ngot < 4) begin
                got[ngot] = out_data; gl[ngot] = out_last; ngot++;
                if (out_last) done = 1;
            end
            @(posedge clk); @(negedge clk);
        end
        rd_req = 1'b0; cfg_wr = 1'b0; out_ready = 1'b0;
        chk(rd_ready == 1'b1, "R9 ready after last word", 32'(rd_ready), 32'd1);
    endtask

    task automatic verify(input logic [15:0] c, input int off, input string tag);
        int nw = exp_words(c);
        chk(ngot == nw, {tag, " word count"}, 32'(ngot), 32'(nw));
        for (int k = 0; k < ngot && k < nw; k++) begin
            chk(got[k] == exp_word(c, off, k), {tag, " word data"}, got[k], exp_word(c, off, k));
            chk(gl[k] == (k == nw - 1), {tag, " R7 last flag"}, 32'(gl[k]), 32'(k == nw - 1));
        end
    endtask

    initial begin
        #(4 * 20000);
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_ready == 1'b1 && out_valid == 1'b0, "R1 reset state",
            {30'd0, rd_ready, out_valid}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset",
            {30'd0, rd_ready, out_valid}, 32'd2);

        // R1: default configuration has burst off, one byte
        run_read(4'd6, 1'b0, 1'b0);
        verify(16'h0000, 6, "R1 default cfg");

        // Table walk, every other entry with backpressure
        for (int v = 0; v < NV; v++) begin
            write_cfg(8'h5D, VEC[v][19:4]);
            run_read(VEC[v][3:0], v[0], 1'b0);
            verify(VEC[v][19:4], int'(VEC[v][3:0]), $sformatf("vec%0d R4", v));
        end

        // R2: write to a neighbouring address is ignored
        write_cfg(8'h5D, 16'h0000);
        write_cfg(8'h5C, 16'h0302);
        run_read(4'd1, 1'b0, 1'b0);
        verify(16'h0000, 1, "R2 foreign address");

        // R9 R11: mid-burst request and config rewrite
        write_cfg(8'h5D, 16'h0301);
        run_read(4'd15, 1'b1, 1'b1);
        verify(16'h0301, 15, "R11 snapshot R9 ignored req");
        // The rewrite (burst off) applies to the next request
        run_read(4'd4, 1'b0, 1'b0);
        verify(16'h0000, 4, "R11 new cfg next request");

        // R8: 32-bit big-endian from offset 15
        write_cfg(8'h5D, 16'h0112);
        run_read(4'd15, 1'b0, 1'b0);
        verify(16'h0112, 15, "R8 R6 wrap big");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule